// File: doc/BRIEF.md
# Translation Cache with Address-Space Tags

This block is a small, fully associative translation cache. It maps a pair made of a virtual page number and an address-space tag to a physical frame number. Every stored entry is compared against the request at the same time. A request is a hit only when both the page number and the tag agree with a valid entry. Entries that carry different tags stay side by side, so translations for several processes can be resident together.

A miss handler outside the block walks the page table and then writes the result through the fill port. If a valid entry already holds the same page number and tag, the fill overwrites that entry in place. Otherwise the fill goes to the lowest-numbered empty slot. When there is no empty slot, a free-running LFSR picks the starting point of a scan, and the scan takes the first entry that is not locked. A fill can mark its entry as locked. A locked entry is never chosen as a victim and is not cleared by a flush. The flush input clears every unlocked entry in one cycle; it is used on a context switch when tag checking cannot separate processes. If every slot is locked and the fill does not match an existing entry, the fill is dropped and an error pulse is raised.

Top module: `xlate_cache`

## Requirements
- R1: While `rst` is high and in the first cycle after it, no entry is valid, `look_ack` and `fill_drop` are 0, and every lookup misses until a fill is made.
- R2: A lookup presented in cycle t gives `look_ack`=1 in cycle t+1, together with `look_hit` and, on a hit, `look_pfn` set to the stored frame number. `look_ack` is 0 in every cycle that follows a cycle without a request, and `look_hit` is never 1 without `look_ack`.
- R3: A lookup hits only when both the page number and the address tag equal those of a valid entry. The same page number under two tags holds two independent frame numbers. A lookup with an unknown tag misses.
- R4: After a fill, a lookup of the same page and tag hits and returns the filled frame. A lookup in the same cycle as a fill sees the contents from before the fill.
- R5: While an empty slot exists, a fill never evicts a valid entry. After `ENTRIES` fills with distinct keys starting from empty, every one of them hits.
- R6: When the cache is full, a fill with a new key evicts exactly one unlocked entry. The new key hits afterwards, and every locked entry still hits. Locked entries are never lost in a cycle without a fill.
- R7: A flush with no fill in the same cycle leaves no unlocked entry valid in the next cycle. All locked entries keep their translations.
- R8: A fill whose page and tag are already present overwrites that entry's frame and lock bit. It creates no duplicate, so at most one entry ever matches a lookup.
- R9: When every entry is valid and locked, a fill with a new key is dropped. `fill_drop` is 1 in the cycle after that fill, and the existing contents are unchanged. A fill that matches an existing key is still accepted, with `fill_drop`=0.
- R10: A fill in the same cycle as a flush is written, and its entry is valid after the flush.
- R11: Refilling a locked key with `fill_lock`=0 unlocks it, so a later flush removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| look_req | input | 1 | Lookup request strobe |
| look_vpn | input | VPN_W | Page number to translate |
| look_asid | input | ASID_W | Address-space tag of the running process |
| fill_req | input | 1 | Fill request strobe |
| fill_vpn | input | VPN_W | Page number to insert |
| fill_asid | input | ASID_W | Address-space tag to insert |
| fill_pfn | input | PFN_W | Frame number to insert |
| fill_lock | input | 1 | Mark the inserted entry as locked (exempt from eviction and flush) |
| flush_req | input | 1 | Invalidate all unlocked entries |
| look_ack | output | 1 | Registered: lookup result valid |
| look_hit | output | 1 | Registered: lookup found a matching valid entry |
| look_pfn | output | PFN_W | Registered: frame number of the matching entry |
| fill_drop | output | 1 | Registered pulse: previous fill dropped because all entries are locked |

## Verification
The assertions take for granted that the fill port never asks for two keys to live at once. The block then keeps at most one matching entry. They also assume that the lock state changes only through fills, so with no fill the set of valid locked entries is fixed. The stimulus issues one fill at a time and one isolated lookup at a time. The bench does not know which victim the LFSR picks. So after an eviction it checks only the behaviour that does not depend on that choice: the number of surviving unlocked entries, and that every locked and newly filled key still hits.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int DEF_ENTRIES = 16;
  localparam int DEF_VPN_W   = 20;
  localparam int DEF_PFN_W   = 20;
  localparam int DEF_ASID_W  = 8;

  localparam int         RND_W    = 8;
  localparam logic [7:0] RND_MASK = 8'hB8;
  localparam logic [7:0] RND_SEED = 8'h5A;

  function automatic logic [RND_W-1:0] rnd_step(input logic [RND_W-1:0] s);
    rnd_step = {1'b0, s[RND_W-1:1]} ^ (s[0] ? RND_MASK : '0);
  endfunction
endpackage

// File: rtl/xlate_match.sv
module xlate_match #(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]      ent_valid,
  input  logic [VPN_W-1:0]  ent_vpn  [N],
  input  logic [ASID_W-1:0] ent_asid [N],
  input  logic [VPN_W-1:0]  key_vpn,
  input  logic [ASID_W-1:0] key_asid,
  output logic [N-1:0]      hit_vec,
  output logic              hit_any,
  output logic [IDX_W-1:0]  hit_idx
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = ent_valid[g] && (ent_vpn[g] == key_vpn) &&
                        (ent_asid[g] == key_asid);
  end

  assign hit_any = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (hit_vec[k]) hit_idx = IDX_W'(k);
    end
  end
endmodule

// File: rtl/xlate_victim.sv
module xlate_victim import xlate_pkg::*; #(
  parameter int N = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     ent_valid,
  input  logic [N-1:0]     ent_lock,
  output logic [IDX_W-1:0] vic_idx,
  output logic             vic_ok
);
  logic [RND_W-1:0] rnd_q;
  logic [IDX_W-1:0] ptr_raw;
  logic [IDX_W-1:0] ptr;
  logic             free_any;
  logic [IDX_W-1:0] free_idx;
  logic             rot_any;
  logic [IDX_W-1:0] rot_idx;

  always_ff @(posedge clk) begin
    if (rst) rnd_q <= RND_SEED;
    else     rnd_q <= rnd_step(rnd_q);
  end

  always_comb begin
    ptr_raw = '0;
    for (int b = 0; b < RND_W; b++) begin
      ptr_raw[b % IDX_W] = ptr_raw[b % IDX_W] ^ rnd_q[b];
    end
    ptr = (int'(ptr_raw) >= N) ? IDX_W'(int'(ptr_raw) - N) : ptr_raw;
  end

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (!ent_valid[k]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(k);
      end
    end
  end

  always_comb begin
    rot_any = 1'b0;
    rot_idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      int j;
      j = int'(ptr) + k;
      if (j >= N) j = j - N;
      if (!ent_lock[j]) begin
        rot_any = 1'b1;
        rot_idx = IDX_W'(j);
      end
    end
  end

  assign vic_ok  = free_any || rot_any;
  assign vic_idx = free_any ? free_idx : rot_idx;
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache import xlate_pkg::*; #(
  parameter int ENTRIES = DEF_ENTRIES,
  parameter int VPN_W   = DEF_VPN_W,
  parameter int PFN_W   = DEF_PFN_W,
  parameter int ASID_W  = DEF_ASID_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              look_req,
  input  logic [VPN_W-1:0]  look_vpn,
  input  logic [ASID_W-1:0] look_asid,
  input  logic              fill_req,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic              fill_lock,
  input  logic              flush_req,
  output logic              look_ack,
  output logic              look_hit,
  output logic [PFN_W-1:0]  look_pfn,
  output logic              fill_drop
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] lock_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];

  logic [ENTRIES-1:0] lk_vec;
  logic               lk_any;
  logic [IDX_W-1:0]   lk_idx;
  logic [ENTRIES-1:0] fm_vec;
  logic               fm_any;
  logic [IDX_W-1:0]   fm_idx;
  logic [IDX_W-1:0]   vic_idx;
  logic               vic_ok;
  logic               wr_en;
  logic [IDX_W-1:0]   wr_idx;

  xlate_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_look_cmp (
    .ent_valid (valid_q),
    .ent_vpn   (vpn_q),
    .ent_asid  (asid_q),
    .key_vpn   (look_vpn),
    .key_asid  (look_asid),
    .hit_vec   (lk_vec),
    .hit_any   (lk_any),
    .hit_idx   (lk_idx)
  );

  xlate_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fill_cmp (
    .ent_valid (valid_q),
    .ent_vpn   (vpn_q),
    .ent_asid  (asid_q),
    .key_vpn   (fill_vpn),
    .key_asid  (fill_asid),
    .hit_vec   (fm_vec),
    .hit_any   (fm_any),
    .hit_idx   (fm_idx)
  );

  xlate_victim #(.N(ENTRIES)) u_victim (
    .clk       (clk),
    .rst       (rst),
    .ent_valid (valid_q),
    .ent_lock  (lock_q),
    .vic_idx   (vic_idx),
    .vic_ok    (vic_ok)
  );

  assign wr_en  = fill_req && (fm_any || vic_ok);
  assign wr_idx = fm_any ? fm_idx : vic_idx;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_state
    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q[g] <= 1'b0;
        lock_q[g]  <= 1'b0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        valid_q[g] <= 1'b1;
        lock_q[g]  <= fill_lock;
      end else if (flush_req && !lock_q[g]) begin
        valid_q[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      vpn_q[wr_idx]  <= fill_vpn;
      asid_q[wr_idx] <= fill_asid;
      pfn_q[wr_idx]  <= fill_pfn;
    end
  end

  always_ff @(posedge clk) begin
    look_pfn <= pfn_q[lk_idx];
    if (rst) begin
      look_ack  <= 1'b0;
      look_hit  <= 1'b0;
      fill_drop <= 1'b0;
    end else begin
      look_ack  <= look_req;
      look_hit  <= look_req && lk_any;
      fill_drop <= fill_req && !fm_any && !vic_ok;
    end
  end
endmodule

// File: rtl/xlate_cache_chk.sv
module xlate_cache_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         look_req,
  input logic         look_ack,
  input logic         look_hit,
  input logic         fill_req,
  input logic         flush_req,
  input logic         fill_drop,
  input logic [N-1:0] valid_q,
  input logic [N-1:0] lock_q,
  input logic [N-1:0] lk_vec
);
  // R1
  reset_empty_chk: assert property (@(posedge clk)
    rst |=> (valid_q == '0) && !look_ack && !fill_drop);

  // R2
  ack_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    look_req |=> look_ack);

  // R2
  no_spurious_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !look_req |=> !look_ack);

  // R2
  hit_needs_ack_chk: assert property (@(posedge clk) disable iff (rst)
    look_hit |-> look_ack);

  // R8
  single_match_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_vec));

  // R7
  flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (flush_req && !fill_req) |=> ((valid_q & ~lock_q) == '0));

  // R6
  locked_kept_chk: assert property (@(posedge clk) disable iff (rst)
    !fill_req |=> ((valid_q & lock_q) == $past(valid_q & lock_q)));

  // R9
  drop_cause_chk: assert property (@(posedge clk) disable iff (rst)
    fill_drop |-> $past(fill_req && ((valid_q & lock_q) == {N{1'b1}})));
endmodule

bind xlate_cache xlate_cache_chk #(.N(ENTRIES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .look_req  (look_req),
  .look_ack  (look_ack),
  .look_hit  (look_hit),
  .fill_req  (fill_req),
  .flush_req (flush_req),
  .fill_drop (fill_drop),
  .valid_q   (valid_q),
  .lock_q    (lock_q),
  .lk_vec    (lk_vec)
);

// File: tb/sim_xlate_cache.sv
module sim_xlate_cache;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        look_req = 1'b0;
  logic [19:0] look_vpn = '0;
  logic [7:0]  look_asid = '0;
  logic        fill_req = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [7:0]  fill_asid = '0;
  logic [19:0] fill_pfn = '0;
  logic        fill_lock = 1'b0;
  logic        flush_req = 1'b0;
  logic        look_ack;
  logic        look_hit;
  logic [19:0] look_pfn;
  logic        fill_drop;

  always #4 clk = ~clk;

  xlate_cache u0 (
    .clk(clk), .rst(rst),
    .look_req(look_req), .look_vpn(look_vpn), .look_asid(look_asid),
    .fill_req(fill_req), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
    .fill_pfn(fill_pfn), .fill_lock(fill_lock), .flush_req(flush_req),
    .look_ack(look_ack), .look_hit(look_hit), .look_pfn(look_pfn),
    .fill_drop(fill_drop)
  );

  typedef struct {
    logic        care;
    logic        hit;
    logic [19:0] pfn;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad = 0;
  int   probe_hits = 0;
  logic last_drop = 1'b0;
  int   cyc = 0;
  bit   done = 1'b0;

  task automatic report;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!done && cyc > 50000) begin
      bad++;
      total++;
      $display("FAIL watchdog: act=%0d cycles exp<50000", cyc);
      done = 1'b1;
      report();
    end
  end

  // monitor: scoreboard compare
  always @(negedge clk) begin
    if (!rst && look_ack) begin
      if (q.size() == 0) begin
        total++;
        bad++;
        $display("FAIL R2 unexpected ack: act=1 exp=0");
      end else begin
        exp_t e;
        e = q.pop_front();
        if (e.care) begin
          total++;
          if (look_hit !== e.hit || (e.hit && look_pfn !== e.pfn)) begin
            bad++;
            $display("FAIL %s: act hit=%0b pfn=%h exp hit=%0b pfn=%h",
                     e.tag, look_hit, look_pfn, e.hit, e.pfn);
          end
        end else if (look_hit) begin
          probe_hits++;
        end
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic look(input logic [19:0] v, input logic [7:0] a, input logic care,
                      input logic eh, input logic [19:0] ep, input string tag);
    exp_t e;
    e.care = care; e.hit = eh; e.pfn = ep; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    look_req = 1'b1; look_vpn = v; look_asid = a;
    @(negedge clk);
    look_req = 1'b0;
  endtask

  task automatic fill(input logic [19:0] v, input logic [7:0] a, input logic [19:0] p,
                      input logic lk, input logic fl);
    @(negedge clk);
    fill_req = 1'b1; fill_vpn = v; fill_asid = a; fill_pfn = p; fill_lock = lk;
    flush_req = fl;
    @(negedge clk);
    fill_req = 1'b0; flush_req = 1'b0;
    last_drop = fill_drop;
  endtask

  task automatic flush;
    @(negedge clk);
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: empty after reset
    check("R1 drop after reset", int'(fill_drop), 0);
    look(20'h100, 8'd1, 1, 0, 0, "R1 empty miss");

    // R4: lookup in same cycle as fill sees old contents
    begin
      exp_t e;
      e.care = 1; e.hit = 0; e.pfn = 0; e.tag = "R4 same-cycle miss";
      q.push_back(e);
      @(negedge clk);
      fill_req = 1; fill_vpn = 20'h100; fill_asid = 8'd1; fill_pfn = 20'h000A0;
      fill_lock = 0;
      look_req = 1; look_vpn = 20'h100; look_asid = 8'd1;
      @(negedge clk);
      fill_req = 0; look_req = 0;
    end
    look(20'h100, 8'd1, 1, 1, 20'h000A0, "R4 hit after fill");

    // R3: same page, two tags
    fill(20'h100, 8'd2, 20'h000B0, 0, 0);
    look(20'h100, 8'd1, 1, 1, 20'h000A0, "R3 tag1");
    look(20'h100, 8'd2, 1, 1, 20'h000B0, "R3 tag2");
    look(20'h100, 8'd3, 1, 0, 0, "R3 tag mismatch miss");

    // R8: overwrite in place
    fill(20'h100, 8'd1, 20'h000C0, 0, 0);
    look(20'h100, 8'd1, 1, 1, 20'h000C0, "R8 overwrite");

    // R5: fill the remaining 14 slots, 4 locked
    for (int i = 0; i < 14; i++)
      fill(20'h200 + 20'(i), 8'd5, 20'h300 + 20'(i), (i < 4), 0);
    look(20'h100, 8'd1, 1, 1, 20'h000C0, "R5 R8 no duplicate");
    look(20'h100, 8'd2, 1, 1, 20'h000B0, "R5 entry kept");
    for (int i = 0; i < 14; i++)
      look(20'h200 + 20'(i), 8'd5, 1, 1, 20'h300 + 20'(i), "R5 all resident");

    // R6: eviction when full
    fill(20'h900, 8'd7, 20'h00999, 0, 0);
    check("R6 no drop when unlocked exist", int'(last_drop), 0);
    look(20'h900, 8'd7, 1, 1, 20'h00999, "R6 new key hits");
    for (int i = 0; i < 4; i++)
      look(20'h200 + 20'(i), 8'd5, 1, 1, 20'h300 + 20'(i), "R6 locked survives");
    probe_hits = 0;
    look(20'h100, 8'd1, 0, 0, 0, "");
    look(20'h100, 8'd2, 0, 0, 0, "");
    for (int i = 4; i < 14; i++)
      look(20'h200 + 20'(i), 8'd5, 0, 0, 0, "");
    repeat (2) @(negedge clk);
    check("R6 one unlocked evicted", probe_hits, 11);

    // R7: flush
    flush();
    look(20'h900, 8'd7, 1, 0, 0, "R7 unlocked cleared");
    look(20'h204, 8'd5, 1, 0, 0, "R7 unlocked cleared");
    look(20'h200, 8'd5, 1, 1, 20'h300, "R7 locked kept");

    // R10: fill with flush in same cycle
    fill(20'hA00, 8'd3, 20'h01234, 0, 1);
    look(20'hA00, 8'd3, 1, 1, 20'h01234, "R10 fill survives flush");

    // R11: unlock via refill
    fill(20'h200, 8'd5, 20'h00777, 0, 0);
    look(20'h200, 8'd5, 1, 1, 20'h00777, "R11 refill value");
    flush();
    look(20'h200, 8'd5, 1, 0, 0, "R11 unlocked then flushed");
    look(20'h201, 8'd5, 1, 1, 20'h301, "R11 other locked kept");

    // R1 again, then R9: all locked
    do_reset();
    check("R1 drop after reset", int'(fill_drop), 0);
    look(20'h201, 8'd5, 1, 0, 0, "R1 reset clears");
    for (int i = 0; i < 16; i++)
      fill(20'h400 + 20'(i), 8'd9, 20'h500 + 20'(i), 1, 0);
    check("R9 no drop while filling", int'(last_drop), 0);
    fill(20'h4FF, 8'd9, 20'h00FFF, 0, 0);
    check("R9 drop pulse", int'(last_drop), 1);
    @(negedge clk);
    check("R9 drop is a pulse", int'(fill_drop), 0);
    look(20'h4FF, 8'd9, 1, 0, 0, "R9 dropped key misses");
    look(20'h40F, 8'd9, 1, 1, 20'h50F, "R9 contents intact");
    fill(20'h405, 8'd9, 20'h00666, 1, 0);
    check("R9 R8 matching fill accepted", int'(last_drop), 0);
    look(20'h405, 8'd9, 1, 1, 20'h00666, "R9 R8 matching fill value");
    flush();
    look(20'h400, 8'd9, 1, 1, 20'h500, "R7 locked after flush");

    repeat (3) @(negedge clk);
    check("R2 all results returned", q.size(), 0);
    done = 1'b1;
    report();
  end
endmodule